// File: doc/BRIEF.md
# Per-Portion Parity Checker with Retransmission Requests

This block sits on the receive side of a network-on-chip endpoint. Each arriving packet carries a 28-bit header and a 36-bit payload made of four byte portions, each followed by its own parity bit. The block recomputes the parity of every portion. Portions that check correctly are forwarded one cycle later. A failing portion is discarded and recorded as an outstanding request, and the block emits a negative acknowledgement (NAK) naming the sender, the packet number and the portion. Clean packets are accepted silently.

The block also tracks the packet number of each source. When an arriving packet skips one or more numbers (modulo 1024), the missing packets are requested portion by portion. Outstanding requests sit in a small table. An entry that goes unanswered is re-issued after a fixed timeout, which covers lost NAKs. An entry is cleared when a resent portion with good parity arrives. The sender's resend is a packet with the resend flag set, and only the portion named in its header is used.

Header layout: source `[27:23]`, destination `[22:18]`, packet number `[17:8]`, portion number `[7:6]`, control `[5:0]` with control bit 0 as the resend flag. The destination and the other control bits are carried but not used.

Top module: `portion_check_rx`

## Requirements
- R1: Portion k (k = 0..3) occupies payload bits `[35-9k : 28-9k]`, and its parity bit is bit `27-9k`. With `cfg_odd` = 0 a portion is good when the parity bit equals the XOR of its eight bits. With `cfg_odd` = 1 it is good when the parity bit equals the inverse of that XOR.
- R2: For a new packet (resend flag 0), every good portion is forwarded on the clock edge after the packet is sampled. `fwd_keep[k]` is set and `fwd_data[8k+7:8k]` holds portion k; `fwd_src` and `fwd_pkt` come from the header. `fwd_valid` is high when at least one bit of `fwd_keep` is set.
- R3: A portion with a parity mismatch is never forwarded (its `fwd_keep` bit is 0). It creates an outstanding request for (source, packet, portion).
- R4: A NAK is a one-cycle pulse on `nak_valid`. `nak_word` = {source[16:12], packet[11:2], portion[1:0]}. At most one NAK is emitted per cycle, and none is emitted while the table is empty. With the table idle, the first NAK of a new request appears on the second clock edge after the packet is sampled. Requests created together by one packet are emitted on consecutive cycles: skipped packets first, oldest first, each in ascending portion order, then failing portions in ascending order.
- R5: A new packet with four good portions and no sequence gap produces no NAK.
- R6: Packet numbers are tracked per source. The first packet seen from a source since reset sets the baseline and requests nothing. A later new packet whose number exceeds the expected one (modulo 1024, with wraparound) requests all four portions of each skipped packet, as far as the table capacity allows. The expected number then becomes the received number plus one.
- R7: An outstanding request that is not cleared is re-issued every TIMEOUT cycles.
- R8: In a resend packet, only the portion named in the header is checked and forwarded; the other portions are ignored. A good resend portion clears the matching request, and no further NAK for it follows. A bad resend portion is dropped and the request remains. Resends do not affect sequence tracking.
- R9: When the table is full, new requests are dropped and never emitted.
- R10: An even number of bit flips within one portion goes undetected: the portion is forwarded and no NAK is raised.
- R11: During and after reset, `fwd_valid` and `nak_valid` are low, the table is empty and every source's baseline is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_odd | input | 1 | Parity polarity: 0 even, 1 odd |
| in_valid | input | 1 | Packet present this cycle |
| in_header | input | 28 | Packet header |
| in_data | input | 36 | Four byte portions with parity |
| fwd_valid | output | 1 | Forwarded data valid |
| fwd_src | output | 5 | Source of forwarded data |
| fwd_pkt | output | 10 | Packet number of forwarded data |
| fwd_keep | output | 4 | Per-portion forward mask |
| fwd_data | output | 32 | Forwarded portions, portion k in byte k |
| nak_valid | output | 1 | NAK pulse |
| nak_word | output | 17 | NAK contents: source, packet, portion |

## Verification
A table entry with a wrong timer shows up at `nak_valid` within one timeout period, as a repeat that comes too early or too late. A stale entry that a resend failed to clear shows up as a NAK within TIMEOUT cycles after the resend. A wrong baseline in the sequence tracker produces spurious or missing NAKs two edges after the next packet from that source. A parity lane with the wrong polarity is visible on `fwd_keep` on the very next edge. The bench therefore timestamps every NAK and checks its order, its spacing and its absence over windows longer than the timeout.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
  localparam int SRC_W  = 5;
  localparam int DST_W  = 5;
  localparam int PKT_W  = 10;
  localparam int PRT_W  = 2;
  localparam int CTL_W  = 6;
  localparam int HDR_W  = SRC_W + DST_W + PKT_W + PRT_W + CTL_W;
  localparam int LANES  = 1 << PRT_W;
  localparam int BYTE_W = 8;
  localparam int LANE_W = BYTE_W + 1;
  localparam int DATA_W = LANES * LANE_W;
  localparam int NAK_W  = SRC_W + PKT_W + PRT_W;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DST_W-1:0] dst;
    logic [PKT_W-1:0] pkt;
    logic [PRT_W-1:0] prt;
    logic [CTL_W-1:0] ctl;
  } hdr_t;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [PKT_W-1:0] pkt;
    logic [PRT_W-1:0] prt;
  } nak_req_t;

  // Parity bit a sender places after a byte for the chosen polarity.
  function automatic logic want_parity(input logic [BYTE_W-1:0] b, input logic odd);
    return (^b) ^ odd;
  endfunction

  // Packets skipped between the expected and the received number.
  function automatic logic [PKT_W-1:0] skip_count(input logic [PKT_W-1:0] expect_n,
                                                  input logic [PKT_W-1:0] got_n);
    return got_n - expect_n;
  endfunction
endpackage

// File: rtl/pchk_lane.sv
module pchk_lane
  import pchk_pkg::*;
(
  input  logic [LANE_W-1:0] lane_i,
  input  logic              odd_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ok_o
);
  assign byte_o = lane_i[LANE_W-1:1];
  assign ok_o   = (want_parity(lane_i[LANE_W-1:1], odd_i) == lane_i[0]);
endmodule

// File: rtl/pchk_seq.sv
module pchk_seq
  import pchk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [PKT_W-1:0] pkt_i,
  output logic [PKT_W-1:0] gap_o,
  output logic [PKT_W-1:0] exp_o
);
  localparam int NSRC = 1 << SRC_W;

  logic [PKT_W-1:0] exp_r  [NSRC];
  logic [NSRC-1:0]  seen_r;

  assign exp_o = exp_r[src_i];
  assign gap_o = seen_r[src_i] ? skip_count(exp_r[src_i], pkt_i) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_r <= '0;
      for (int i = 0; i < NSRC; i++) exp_r[i] <= '0;
    end else if (upd_i) begin
      seen_r[src_i] <= 1'b1;
      exp_r[src_i]  <= pkt_i + PKT_W'(1);
    end
  end
endmodule

// File: rtl/pchk_nak_table.sv
module pchk_nak_table
  import pchk_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TIMEOUT = 64,
  parameter int NCAND   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCAND-1:0]   cand_v,
  input  nak_req_t           cand_q [NCAND],
  input  logic               clr_v,
  input  nak_req_t           clr_q,
  output logic               emit_v,
  output nak_req_t           emit_q,
  output logic [ENTRIES-1:0] ins_mask,
  output logic [ENTRIES-1:0] clr_mask,
  output logic [ENTRIES-1:0] live_mask
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TMR_W = $clog2(TIMEOUT + 1);
  localparam logic [TMR_W-1:0] RELOAD = TMR_W'(TIMEOUT - 2);

  logic [ENTRIES-1:0] live_r, due_r;
  nak_req_t           ent_q [ENTRIES];
  logic [TMR_W-1:0]   tmr_r [ENTRIES];
  nak_req_t           ins_q [ENTRIES];
  logic [IDX_W-1:0]   emit_idx;

  assign live_mask = live_r;

  // Place each fresh, non-duplicate candidate into the lowest free slot.
  always_comb begin
    logic [ENTRIES-1:0] taken;
    logic dup, placed;
    taken    = live_r;
    ins_mask = '0;
    for (int s = 0; s < ENTRIES; s++) ins_q[s] = '0;
    for (int c = 0; c < NCAND; c++) begin
      dup = 1'b0;
      for (int s = 0; s < ENTRIES; s++)
        if (live_r[s] && ent_q[s] == cand_q[c]) dup = 1'b1;
      placed = 1'b0;
      if (cand_v[c] && !dup) begin
        for (int s = 0; s < ENTRIES; s++) begin
          if (!placed && !taken[s]) begin
            taken[s]    = 1'b1;
            ins_mask[s] = 1'b1;
            ins_q[s]    = cand_q[c];
            placed      = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < ENTRIES; s++)
      clr_mask[s] = live_r[s] && clr_v && (ent_q[s] == clr_q);
  end

  always_comb begin
    emit_v   = 1'b0;
    emit_idx = '0;
    for (int s = 0; s < ENTRIES; s++) begin
      if (!emit_v && live_r[s] && due_r[s] && !clr_mask[s]) begin
        emit_v   = 1'b1;
        emit_idx = IDX_W'(s);
      end
    end
  end
  assign emit_q = ent_q[emit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_r <= '0;
      due_r  <= '0;
      for (int s = 0; s < ENTRIES; s++) begin
        ent_q[s] <= '0;
        tmr_r[s] <= '0;
      end
    end else begin
      for (int s = 0; s < ENTRIES; s++) begin
        if (clr_mask[s]) begin
          live_r[s] <= 1'b0;
          due_r[s]  <= 1'b0;
        end else if (ins_mask[s]) begin
          live_r[s] <= 1'b1;
          due_r[s]  <= 1'b1;
          ent_q[s]  <= ins_q[s];
          tmr_r[s]  <= '0;
        end else if (live_r[s]) begin
          if (emit_v && emit_idx == IDX_W'(s)) begin
            due_r[s] <= 1'b0;
            tmr_r[s] <= RELOAD;
          end else if (!due_r[s]) begin
            if (tmr_r[s] == '0) due_r[s] <= 1'b1;
            else                tmr_r[s] <= tmr_r[s] - TMR_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/portion_check_rx.sv
module portion_check_rx
  import pchk_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TIMEOUT = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_odd,
  input  logic                    in_valid,
  input  logic [HDR_W-1:0]        in_header,
  input  logic [DATA_W-1:0]       in_data,
  output logic                    fwd_valid,
  output logic [SRC_W-1:0]        fwd_src,
  output logic [PKT_W-1:0]        fwd_pkt,
  output logic [LANES-1:0]        fwd_keep,
  output logic [LANES*BYTE_W-1:0] fwd_data,
  output logic                    nak_valid,
  output logic [NAK_W-1:0]        nak_word
);
  localparam int NCAND = ENTRIES + LANES;

  hdr_t hdr;
  assign hdr = hdr_t'(in_header);

  logic is_resend, new_pkt;
  assign is_resend = hdr.ctl[0];
  assign new_pkt   = in_valid && !is_resend;

  logic unused_hdr_bits;
  assign unused_hdr_bits = ^{hdr.dst, hdr.ctl[CTL_W-1:1]};

  // Parity lanes
  logic [LANES-1:0][BYTE_W-1:0] lane_byte;
  logic [LANES-1:0]             lane_ok;
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pchk_lane u_lane (
      .lane_i (in_data[DATA_W-1-k*LANE_W -: LANE_W]),
      .odd_i  (cfg_odd),
      .byte_o (lane_byte[k]),
      .ok_o   (lane_ok[k])
    );
  end

  // Sequence tracking
  logic [PKT_W-1:0] gap_cnt, exp_pkt;
  pchk_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .upd_i (new_pkt),
    .src_i (hdr.src),
    .pkt_i (hdr.pkt),
    .gap_o (gap_cnt),
    .exp_o (exp_pkt)
  );

  // Request candidates: skipped packets first, then failing portions
  logic [NCAND-1:0] cand_v;
  nak_req_t         cand_q [NCAND];
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      cand_v[i]     = new_pkt && (gap_cnt > PKT_W'(i / LANES));
      cand_q[i].src = hdr.src;
      cand_q[i].pkt = exp_pkt + PKT_W'(i / LANES);
      cand_q[i].prt = PRT_W'(i % LANES);
    end
    for (int k = 0; k < LANES; k++) begin
      cand_v[ENTRIES+k]     = new_pkt && !lane_ok[k];
      cand_q[ENTRIES+k].src = hdr.src;
      cand_q[ENTRIES+k].pkt = hdr.pkt;
      cand_q[ENTRIES+k].prt = PRT_W'(k);
    end
  end

  // Resend handling
  logic [LANES-1:0] sel_mask, keep;
  logic             clr_v;
  nak_req_t         clr_q;
  always_comb begin
    sel_mask          = '0;
    sel_mask[hdr.prt] = 1'b1;
    keep              = is_resend ? (lane_ok & sel_mask) : lane_ok;
    clr_v             = in_valid && is_resend && lane_ok[hdr.prt];
    clr_q.src         = hdr.src;
    clr_q.pkt         = hdr.pkt;
    clr_q.prt         = hdr.prt;
  end

  logic               emit_v;
  nak_req_t           emit_q;
  logic [ENTRIES-1:0] ins_mask, clr_mask, live_mask;
  pchk_nak_table #(
    .ENTRIES (ENTRIES),
    .TIMEOUT (TIMEOUT),
    .NCAND   (NCAND)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand_v    (cand_v),
    .cand_q    (cand_q),
    .clr_v     (clr_v),
    .clr_q     (clr_q),
    .emit_v    (emit_v),
    .emit_q    (emit_q),
    .ins_mask  (ins_mask),
    .clr_mask  (clr_mask),
    .live_mask (live_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_keep  <= '0;
      fwd_data  <= '0;
      fwd_src   <= '0;
      fwd_pkt   <= '0;
      nak_valid <= 1'b0;
      nak_word  <= '0;
    end else begin
      fwd_valid <= in_valid && (|keep);
      fwd_keep  <= in_valid ? keep : '0;
      if (in_valid) begin
        fwd_data <= lane_byte;
        fwd_src  <= hdr.src;
        fwd_pkt  <= hdr.pkt;
      end
      nak_valid <= emit_v;
      nak_word  <= emit_q;
    end
  end
endmodule

// File: rtl/pchk_checker.sv
module pchk_checker #(
  parameter int ENTRIES = 8,
  parameter int LANES   = 4,
  parameter int PKT_W   = 10,
  parameter int NAK_W   = 17
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               is_resend,
  input logic [LANES-1:0]   lane_ok,
  input logic [PKT_W-1:0]   gap_cnt,
  input logic [ENTRIES-1:0] ins_mask,
  input logic [ENTRIES-1:0] clr_mask,
  input logic [ENTRIES-1:0] live_mask,
  input logic               fwd_valid,
  input logic [LANES-1:0]   fwd_keep,
  input logic               nak_valid,
  input logic [NAK_W-1:0]   nak_word
);
  assert_clean_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_resend && (&lane_ok)) |=> (fwd_valid && (&fwd_keep)));

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    assert_drop_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !lane_ok[k]) |=> !fwd_keep[k]);
  end

  assert_silent_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_resend && (&lane_ok) && gap_cnt == '0) |-> (ins_mask == '0));

  assert_quiet_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_mask == '0) |=> !nak_valid);

  assert_no_b2b_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nak_valid |=> !(nak_valid && nak_word == $past(nak_word)));

  for (genvar s = 0; s < ENTRIES; s++) begin : g_slot_chk
    assert_clear_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_mask[s] |=> !live_mask[s]);
  end
endmodule

bind portion_check_rx pchk_checker #(
  .ENTRIES (ENTRIES)
) u_pchk_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .is_resend (is_resend),
  .lane_ok   (lane_ok),
  .gap_cnt   (gap_cnt),
  .ins_mask  (ins_mask),
  .clr_mask  (clr_mask),
  .live_mask (live_mask),
  .fwd_valid (fwd_valid),
  .fwd_keep  (fwd_keep),
  .nak_valid (nak_valid),
  .nak_word  (nak_word)
);

// File: tb/portion_check_rx_bench.sv
module portion_check_rx_bench;
  localparam int ENTRIES = 8;
  localparam int TIMEOUT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_odd = 1'b0;
  logic        in_valid = 1'b0;
  logic [27:0] in_header = '0;
  logic [35:0] in_data = '0;
  logic        fwd_valid;
  logic [4:0]  fwd_src;
  logic [9:0]  fwd_pkt;
  logic [3:0]  fwd_keep;
  logic [31:0] fwd_data;
  logic        nak_valid;
  logic [16:0] nak_word;

  portion_check_rx #(.ENTRIES(ENTRIES), .TIMEOUT(TIMEOUT)) u_portion_check_rx (
    .clk(clk), .rst_n(rst_n), .cfg_odd(cfg_odd), .in_valid(in_valid),
    .in_header(in_header), .in_data(in_data), .fwd_valid(fwd_valid),
    .fwd_src(fwd_src), .fwd_pkt(fwd_pkt), .fwd_keep(fwd_keep),
    .fwd_data(fwd_data), .nak_valid(nak_valid), .nak_word(nak_word));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, nlog = 0, sent_cyc = 0;
  bit done = 1'b0;
  logic [16:0] log_w [512];
  int          log_c [512];
  logic        cap_v;
  logic [3:0]  cap_keep;
  logic [31:0] cap_data;
  logic [4:0]  cap_src;
  logic [9:0]  cap_pkt;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk)
    if (rst_n && nak_valid && nlog < 512) begin
      log_w[nlog] = nak_word;
      log_c[nlog] = cyc;
      nlog = nlog + 1;
    end

  function automatic logic [35:0] mk(input logic [31:0] v, input logic odd);
    logic [35:0] d = '0;
    for (int k = 0; k < 4; k++) begin
      d[35-9*k -: 8] = v[8*k +: 8];
      d[27-9*k]      = (($countones(v[8*k +: 8]) % 2) == 1) ^ odd;
    end
    return d;
  endfunction

  function automatic logic [27:0] hdr(input int src, input int pkt, input int prt, input bit rs);
    return {5'(src), 5'd0, 10'(pkt), 2'(prt), 5'd0, rs};
  endfunction

  function automatic logic [16:0] nw(input int src, input int pkt, input int prt);
    return {5'(src), 10'(pkt), 2'(prt)};
  endfunction

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [27:0] h, input logic [35:0] d);
    tick();
    in_header = h; in_data = d; in_valid = 1'b1; sent_cyc = cyc;
    tick();
    cap_v = fwd_valid; cap_keep = fwd_keep; cap_data = fwd_data;
    cap_src = fwd_src; cap_pkt = fwd_pkt;
    in_valid = 1'b0;
  endtask

  task automatic find_nak(input logic [16:0] w, input int from,
                          output int cnt, output int first, output int second);
    cnt = 0; first = -1; second = -1;
    for (int i = from; i < nlog; i++)
      if (log_w[i] == w) begin
        if (cnt == 0) first = log_c[i];
        else if (cnt == 1) second = log_c[i];
        cnt++;
      end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  localparam logic [31:0] V = 32'h81_0F_3C_A5;

  task automatic t_reset();
    tick();
    check("R11 fwd_valid in reset", fwd_valid, 0);
    check("R11 nak_valid in reset", nak_valid, 0);
    rst_n = 1'b1;
    idle(3);
    check("R11 nak_valid after reset", nak_valid, 0);
  endtask

  task automatic t_clean();
    int base = nlog;
    send(hdr(3, 0, 0, 0), mk(V, 0));
    check("R2 keep on clean packet", cap_keep, 4'hF);
    check("R2 valid on clean packet", cap_v, 1);
    check("R2 data bytes", cap_data, V);
    check("R2 source", cap_src, 3);
    check("R2 packet", cap_pkt, 0);
    idle(TIMEOUT + 4);
    check("R5 no NAK for clean packet", nlog - base, 0);
  endtask

  task automatic t_bad();
    int base = nlog, c, f, s, base2;
    logic [35:0] bad = mk(V, 0) ^ (36'd1 << (35 - 18 - 3));
    send(hdr(3, 1, 0, 0), bad);
    c = sent_cyc;
    check("R3 failing portion dropped", cap_keep, 4'b1011);
    idle(TIMEOUT + 6);
    find_nak(nw(3, 1, 2), base, s, f, s);
    find_nak(nw(3, 1, 2), base, c, f, s);
    check("R4 first NAK timing", f, sent_cyc + 2);
    check("R7 repeat spacing", s - f, TIMEOUT);
    check("R3 only one request", nlog - base >= 2 && log_w[base] == nw(3, 1, 2), 1);
    send(hdr(3, 1, 2, 1), bad);
    check("R8 bad resend dropped", {cap_v, cap_keep}, 5'b0);
    send(hdr(3, 1, 2, 1), mk(V, 0) ^ 36'h8_0000_0000);
    check("R8 only named portion forwarded", cap_keep, 4'b0100);
    check("R8 resend byte", cap_data[23:16], V[23:16]);
    idle(2);
    base2 = nlog;
    idle(TIMEOUT + 4);
    check("R8 NAK stops after good resend", nlog - base2, 0);
  endtask

  task automatic t_odd();
    int base, c, f, s;
    cfg_odd = 1'b1;
    base = nlog;
    send(hdr(3, 2, 0, 0), mk(V, 1));
    check("R1 odd polarity accepted", cap_keep, 4'hF);
    send(hdr(3, 3, 0, 0), mk(V, 0));
    check("R1 even parity rejected under odd", cap_keep, 4'h0);
    idle(6);
    for (int p = 0; p < 4; p++) begin
      find_nak(nw(3, 3, p), base, c, f, s);
      check("R4 portion order and timing", f, sent_cyc + 2 + p);
    end
    find_nak(nw(3, 2, 0), base, c, f, s);
    check("R5 clean odd packet silent", c, 0);
    for (int p = 0; p < 4; p++) send(hdr(3, 3, p, 1), mk(V, 1));
    cfg_odd = 1'b0;
    idle(2);
  endtask

  task automatic t_even_flip();
    int base = nlog;
    send(hdr(3, 4, 0, 0), mk(V, 0) ^ (36'h3 << 20));
    check("R10 double flip passes", cap_keep, 4'hF);
    idle(TIMEOUT + 4);
    check("R10 no NAK on double flip", nlog - base, 0);
  endtask

  task automatic t_gap();
    int base = nlog, c, f, s, base2;
    send(hdr(3, 7, 0, 0), mk(V, 0));
    check("R6 gap packet itself forwarded", cap_keep, 4'hF);
    idle(10);
    for (int i = 0; i < 8; i++)
      check("R6 skipped packet requests in order", {log_w[base+i], 32'(log_c[base+i])},
            {nw(3, 5 + i / 4, i % 4), 32'(sent_cyc + 2 + i)});
    send(hdr(3, 8, 0, 0), mk(V, 0) ^ 36'h1_0000_0000);
    check("R9 bad byte dropped when full", cap_keep, 4'b1110);
    for (int i = 0; i < 8; i++) send(hdr(3, 5 + i / 4, i % 4, 1), mk(V, 0));
    idle(2);
    base2 = nlog;
    idle(TIMEOUT + 4);
    find_nak(nw(3, 8, 0), base, c, f, s);
    check("R9 request dropped when table full", c, 0);
    check("R8 table drained", nlog - base2, 0);
  endtask

  task automatic t_wrap();
    int base = nlog, c, f, s;
    send(hdr(7, 1023, 0, 0), mk(V, 0));
    idle(4);
    check("R6 first packet sets baseline", nlog - base, 0);
    send(hdr(7, 1, 0, 0), mk(V, 0));
    idle(6);
    for (int p = 0; p < 4; p++) begin
      find_nak(nw(7, 0, p), base, c, f, s);
      check("R6 wraparound skip", f, sent_cyc + 2 + p);
    end
    find_nak(nw(7, 1023, 0), base, c, f, s);
    check("R6 no request for received packet", c, 0);
    for (int p = 0; p < 4; p++) send(hdr(7, 0, p, 1), mk(V, 0));
    idle(2);
    base = nlog;
    idle(TIMEOUT + 4);
    check("R8 wrap requests cleared", nlog - base, 0);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_bad();
    t_odd();
    t_even_flip();
    t_gap();
    t_wrap();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule